// File: doc/BRIEF.md
# Region-Based Memory Protection Checker

This block screens memory requests against sixteen programmable protection windows. Every window covers a range of 4 KB pages, carries a 10-bit owner identifier with a 10-bit compare mask, a secure attribute, separate read and write grants, and an enable. A request carries a byte address, a 10-bit requester identifier, a secure flag and a direction flag, qualified by `req_valid`. One clock later the block reports whether the request may proceed. It also reports which window made the decision and raises `err_pulse` for every denial.

Only one window decides each request. Among the enabled windows whose page range holds the address and whose masked identifier agrees with the request, the highest-numbered one wins. Its security attribute and its grant for the request's direction alone settle the outcome. A request that no window claims is refused.

Software programs the windows one field at a time through a write port. The port takes a window index, a field code and a 32-bit data word.

Top module: `mpc_checker`

## Requirements
- R1: After reset every window is disabled with all fields zero, all response outputs are low, and any request is therefore refused with an error.
- R2: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. In every other cycle `rsp_allow`, `rsp_hit`, `rsp_region` and `err_pulse` are zero.
- R3: A window covers a request when start page ≤ address[31:12] ≤ end page, with both ends inclusive. The start and end fields are taken from data bits [31:12] of their writes, and data bits [11:0] are ignored.
- R4: The identifier test passes when `(req_id ^ window_id) & window_mask` is zero. A mask bit of 0 makes that identifier bit a don't-care.
- R5: When several enabled windows claim a request, the highest-numbered one decides, and `rsp_region` reports its index.
- R6: A disabled window never claims a request, whatever its other fields hold.
- R7: A non-secure request (`req_secure`=0) decided by a window marked secure is refused, and `err_pulse` is raised.
- R8: A secure request may use a window marked non-secure, subject to that window's grants.
- R9: A read (`req_write`=0) is allowed only when the deciding window's read grant is set, and a write only when its write grant is set. The other grant has no effect.
- R10: A request that no enabled window claims is refused with `err_pulse` high, `rsp_hit` low and `rsp_region` zero.
- R11: In a response cycle, `err_pulse` is the inverse of `rsp_allow`.
- R12: A field write on the port is used by requests from the next cycle on. A request in the same cycle as the write sees the old value. Field codes on `cfg_field`: 0 start page, 1 end page, 2 identifier (data[9:0]) and mask (data[25:16]), 3 attributes (data bit 0 enable, bit 1 secure, bit 2 read grant, bit 3 write grant).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Field write strobe |
| cfg_region | input | 4 | Window index for the write |
| cfg_field | input | 2 | Field code for the write |
| cfg_wdata | input | 32 | Write data |
| req_valid | input | 1 | Request qualifier |
| req_addr | input | 32 | Request byte address |
| req_id | input | 10 | Requester identifier |
| req_secure | input | 1 | 1 = secure request |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | Decision present |
| rsp_allow | output | 1 | Request may proceed |
| rsp_hit | output | 1 | Some enabled window claimed the request |
| rsp_region | output | 4 | Index of the deciding window |
| err_pulse | output | 1 | One-cycle denial indication |

## Verification
The assertions assume that every input is a known value at each rising edge and that `cfg_region` names an existing window. They make no assumption about the order of start and end pages, so an inverted range simply claims nothing. The bench drives all inputs on the falling edge with defined values. It keeps window indices within range and deliberately programs empty and inverted ranges, overlapping windows and writes that coincide with requests. This covers the cases the assertions leave open.

// File: rtl/mpc_pkg.sv
package mpc_pkg;

  typedef enum logic [1:0] {
    FLD_LO_PAGE = 2'd0,
    FLD_HI_PAGE = 2'd1,
    FLD_ID_MASK = 2'd2,
    FLD_ATTR    = 2'd3
  } cfg_field_e;

  localparam int ATTR_EN_BIT  = 0;
  localparam int ATTR_SEC_BIT = 1;
  localparam int ATTR_RD_BIT  = 2;
  localparam int ATTR_WR_BIT  = 3;
  localparam int MASK_LSB     = 16;

  typedef struct packed {
    logic en;
    logic sec;
    logic rd;
    logic wr;
  } region_attr_t;

endpackage

// File: rtl/mpc_region_bank.sv
module mpc_region_bank
  import mpc_pkg::*;
#(
  parameter int NUM_REGIONS = 16,
  parameter int ADDR_W      = 32,
  parameter int ID_W        = 10,
  parameter int PAGE_BITS   = 12,
  parameter int DATA_W      = 32,
  localparam int IDX_W      = $clog2(NUM_REGIONS),
  localparam int PG_W       = ADDR_W - PAGE_BITS
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 cfg_we,
  input  logic [IDX_W-1:0]                     cfg_region,
  input  cfg_field_e                           cfg_field,
  input  logic [DATA_W-1:0]                    cfg_wdata,
  output logic [NUM_REGIONS-1:0][PG_W-1:0]     lo_pg,
  output logic [NUM_REGIONS-1:0][PG_W-1:0]     hi_pg,
  output logic [NUM_REGIONS-1:0][ID_W-1:0]     id_val,
  output logic [NUM_REGIONS-1:0][ID_W-1:0]     id_mask,
  output region_attr_t [NUM_REGIONS-1:0]       attr
);

  // Bits of the write word that no field uses are folded away here.
  logic unused_wdata;
  assign unused_wdata = ^cfg_wdata;

  // Decoded write data, shared by all windows.
  logic [PG_W-1:0] pg_d;
  logic [ID_W-1:0] idv_d;
  logic [ID_W-1:0] msk_d;
  region_attr_t    attr_d;

  always_comb begin
    pg_d       = cfg_wdata[ADDR_W-1:PAGE_BITS];
    idv_d      = cfg_wdata[ID_W-1:0];
    msk_d      = cfg_wdata[MASK_LSB +: ID_W];
    attr_d.en  = cfg_wdata[ATTR_EN_BIT];
    attr_d.sec = cfg_wdata[ATTR_SEC_BIT];
    attr_d.rd  = cfg_wdata[ATTR_RD_BIT];
    attr_d.wr  = cfg_wdata[ATTR_WR_BIT];
  end

  for (genvar gi = 0; gi < NUM_REGIONS; gi++) begin : g_win
    logic            sel;
    logic            lo_en, hi_en, idm_en, attr_en;
    logic [PG_W-1:0] lo_q, hi_q;
    logic [ID_W-1:0] idv_q, msk_q;
    region_attr_t    attr_q;

    // Next-state: per-field clock enables.
    always_comb begin
      sel     = cfg_we && (cfg_region == IDX_W'(gi));
      lo_en   = sel && (cfg_field == FLD_LO_PAGE);
      hi_en   = sel && (cfg_field == FLD_HI_PAGE);
      idm_en  = sel && (cfg_field == FLD_ID_MASK);
      attr_en = sel && (cfg_field == FLD_ATTR);
    end

    // Registers.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q   <= '0;
        hi_q   <= '0;
        idv_q  <= '0;
        msk_q  <= '0;
        attr_q <= '0;
      end else begin
        if (lo_en)   lo_q   <= pg_d;
        if (hi_en)   hi_q   <= pg_d;
        if (idm_en)  idv_q  <= idv_d;
        if (idm_en)  msk_q  <= msk_d;
        if (attr_en) attr_q <= attr_d;
      end
    end

    assign lo_pg[gi]   = lo_q;
    assign hi_pg[gi]   = hi_q;
    assign id_val[gi]  = idv_q;
    assign id_mask[gi] = msk_q;
    assign attr[gi]    = attr_q;

    // R12: an attribute write is visible in the following cycle.
    a_r12_attr_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_region == IDX_W'(gi) && cfg_field == FLD_ATTR)
        |=> (attr[gi].en == $past(cfg_wdata[ATTR_EN_BIT])));

    // R3: a page write keeps only the page bits of the data word.
    a_r3_lo_page_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_region == IDX_W'(gi) && cfg_field == FLD_LO_PAGE)
        |=> (lo_pg[gi] == $past(cfg_wdata[ADDR_W-1:PAGE_BITS])));
  end

endmodule

// File: rtl/mpc_region_match.sv
module mpc_region_match
  import mpc_pkg::*;
#(
  parameter int NUM_REGIONS = 16,
  parameter int ADDR_W      = 32,
  parameter int ID_W        = 10,
  parameter int PAGE_BITS   = 12,
  localparam int PG_W       = ADDR_W - PAGE_BITS
) (
  input  logic [ADDR_W-1:0]                    req_addr,
  input  logic [ID_W-1:0]                      req_id,
  input  logic [NUM_REGIONS-1:0][PG_W-1:0]     lo_pg,
  input  logic [NUM_REGIONS-1:0][PG_W-1:0]     hi_pg,
  input  logic [NUM_REGIONS-1:0][ID_W-1:0]     id_val,
  input  logic [NUM_REGIONS-1:0][ID_W-1:0]     id_mask,
  input  region_attr_t [NUM_REGIONS-1:0]       attr,
  output logic [NUM_REGIONS-1:0]               hit_vec
);

  logic [PG_W-1:0] req_pg;
  logic            unused_offset;

  assign req_pg        = req_addr[ADDR_W-1:PAGE_BITS];
  assign unused_offset = ^req_addr[PAGE_BITS-1:0];

  for (genvar gi = 0; gi < NUM_REGIONS; gi++) begin : g_cmp
    logic above_lo, below_hi, id_ok;
    always_comb begin
      above_lo    = (req_pg >= lo_pg[gi]);
      below_hi    = (req_pg <= hi_pg[gi]);
      id_ok       = (((req_id ^ id_val[gi]) & id_mask[gi]) == '0);
      hit_vec[gi] = attr[gi].en && above_lo && below_hi && id_ok;
    end
  end

endmodule

// File: rtl/mpc_priority_pick.sv
module mpc_priority_pick #(
  parameter int NUM_REGIONS = 16,
  localparam int IDX_W      = $clog2(NUM_REGIONS)
) (
  input  logic [NUM_REGIONS-1:0] hit_vec,
  output logic                   any_hit,
  output logic [IDX_W-1:0]       win_idx,
  output logic [NUM_REGIONS-1:0] win_onehot
);

  assign any_hit = |hit_vec;

  // Later iterations overwrite earlier ones, so the top set bit wins.
  always_comb begin
    win_idx = '0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (hit_vec[i]) win_idx = IDX_W'(i);
    end
  end

  // Independent one-hot form: a bit survives only if nothing above it is set.
  for (genvar gi = 0; gi < NUM_REGIONS; gi++) begin : g_oh
    if (gi == NUM_REGIONS - 1) begin : g_top
      assign win_onehot[gi] = hit_vec[gi];
    end else begin : g_rest
      assign win_onehot[gi] = hit_vec[gi] && !(|hit_vec[NUM_REGIONS-1:gi+1]);
    end
  end

endmodule

// File: rtl/mpc_checker.sv
module mpc_checker
  import mpc_pkg::*;
#(
  parameter int NUM_REGIONS = 16,
  parameter int ADDR_W      = 32,
  parameter int ID_W        = 10,
  parameter int PAGE_BITS   = 12,
  parameter int DATA_W      = 32,
  localparam int IDX_W      = $clog2(NUM_REGIONS),
  localparam int PG_W       = ADDR_W - PAGE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_region,
  input  logic [1:0]        cfg_field,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ID_W-1:0]   req_id,
  input  logic              req_secure,
  input  logic              req_write,
  output logic              rsp_valid,
  output logic              rsp_allow,
  output logic              rsp_hit,
  output logic [IDX_W-1:0]  rsp_region,
  output logic              err_pulse
);

  logic [NUM_REGIONS-1:0][PG_W-1:0] lo_pg, hi_pg;
  logic [NUM_REGIONS-1:0][ID_W-1:0] id_val, id_mask;
  region_attr_t [NUM_REGIONS-1:0]   attr;
  logic [NUM_REGIONS-1:0]           hit_vec, win_onehot;
  logic                             pick_any;
  logic [IDX_W-1:0]                 win_idx;
  cfg_field_e                       field_code;

  assign field_code = cfg_field_e'(cfg_field);

  mpc_region_bank #(
    .NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W), .ID_W(ID_W),
    .PAGE_BITS(PAGE_BITS), .DATA_W(DATA_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_region(cfg_region),
    .cfg_field(field_code), .cfg_wdata(cfg_wdata),
    .lo_pg(lo_pg), .hi_pg(hi_pg), .id_val(id_val), .id_mask(id_mask), .attr(attr)
  );

  mpc_region_match #(
    .NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W), .ID_W(ID_W), .PAGE_BITS(PAGE_BITS)
  ) u_match (
    .req_addr(req_addr), .req_id(req_id), .lo_pg(lo_pg), .hi_pg(hi_pg),
    .id_val(id_val), .id_mask(id_mask), .attr(attr), .hit_vec(hit_vec)
  );

  mpc_priority_pick #(.NUM_REGIONS(NUM_REGIONS)) u_pick (
    .hit_vec(hit_vec), .any_hit(pick_any), .win_idx(win_idx), .win_onehot(win_onehot)
  );

  // Next-state of the decision.
  region_attr_t     win_attr;
  logic             sec_ok, perm_ok, allow_d, hit_d, err_d;
  logic [IDX_W-1:0] region_d;

  always_comb begin
    win_attr = attr[win_idx];
    sec_ok   = req_secure || !win_attr.sec;
    perm_ok  = req_write ? win_attr.wr : win_attr.rd;
    allow_d  = req_valid && pick_any && sec_ok && perm_ok;
    hit_d    = req_valid && pick_any;
    region_d = hit_d ? win_idx : '0;
    err_d    = req_valid && !(pick_any && sec_ok && perm_ok);
  end

  // Decision registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_allow  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_region <= '0;
      err_pulse  <= 1'b0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_allow  <= allow_d;
      rsp_hit    <= hit_d;
      rsp_region <= region_d;
      err_pulse  <= err_d;
    end
  end

  // R2: one response per request, one cycle later.
  a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_allow && !rsp_hit && !err_pulse && rsp_region == '0));
  // R11: every response is either allowed or flagged.
  a_r11_err_inverts_allow: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (err_pulse != rsp_allow));
  // R10: nothing is allowed without a claiming window.
  a_r10_allow_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_allow |-> rsp_hit);
  // R5: the chosen window is the top claimant.
  a_r5_onehot_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_onehot) && (pick_any == (win_onehot != '0)));
  a_r5_no_higher_claim: assert property (@(posedge clk) disable iff (!rst_n)
    pick_any |-> ((hit_vec >> win_idx) == NUM_REGIONS'(1)));
  // R6: only enabled windows may claim.
  a_r6_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
    pick_any |-> attr[win_idx].en);
  // R7: non-secure traffic into a secure window is refused.
  a_r7_ns_into_secure: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_secure && pick_any && attr[win_idx].sec) |=> (!rsp_allow && err_pulse));

endmodule

// File: tb/sim_mpc_checker.sv
module sim_mpc_checker;

  localparam int CLK_PERIOD = 10;
  localparam int NREG       = 16;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_region = '0;
  logic [1:0]  cfg_field = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [9:0]  req_id = '0;
  logic        req_secure = 1'b0;
  logic        req_write = 1'b0;
  logic        rsp_valid, rsp_allow, rsp_hit, err_pulse;
  logic [3:0]  rsp_region;

  always #(CLK_PERIOD/2) clk = ~clk;

  mpc_checker u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_region(cfg_region),
    .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
    .req_addr(req_addr), .req_id(req_id), .req_secure(req_secure),
    .req_write(req_write), .rsp_valid(rsp_valid), .rsp_allow(rsp_allow),
    .rsp_hit(rsp_hit), .rsp_region(rsp_region), .err_pulse(err_pulse)
  );

  // Behavioural model of the window table.
  int unsigned m_lo[NREG], m_hi[NREG], m_id[NREG], m_mask[NREG];
  bit m_en[NREG], m_sec[NREG], m_rd[NREG], m_wr[NREG];
  bit e_valid = 0, e_allow = 0, e_hit = 0, e_err = 0;
  int e_region = 0;

  int checks = 0;
  int fails  = 0;
  string phase = "R1";

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) begin
        m_lo[r] = 0; m_hi[r] = 0; m_id[r] = 0; m_mask[r] = 0;
        m_en[r] = 0; m_sec[r] = 0; m_rd[r] = 0; m_wr[r] = 0;
      end
      e_valid = 0; e_allow = 0; e_hit = 0; e_err = 0; e_region = 0;
    end else begin
      // Decision uses the table as it stood before this edge's write.
      e_valid = req_valid; e_allow = 0; e_hit = 0; e_err = 0; e_region = 0;
      if (req_valid) begin
        int unsigned pg;
        pg = req_addr >> 12;
        for (int r = NREG - 1; r >= 0; r--) begin
          if (!e_hit && m_en[r] && pg >= m_lo[r] && pg <= m_hi[r] &&
              ((int'(req_id) ^ m_id[r]) & m_mask[r]) == 0) begin
            e_hit = 1; e_region = r;
          end
        end
        if (e_hit)
          e_allow = (req_secure || !m_sec[e_region]) &&
                    (req_write ? m_wr[e_region] : m_rd[e_region]);
        e_err = !e_allow;
      end
      if (cfg_we) begin
        case (cfg_field)
          2'd0: m_lo[cfg_region] = cfg_wdata >> 12;
          2'd1: m_hi[cfg_region] = cfg_wdata >> 12;
          2'd2: begin
            m_id[cfg_region]   = cfg_wdata & 32'h3FF;
            m_mask[cfg_region] = (cfg_wdata >> 16) & 32'h3FF;
          end
          default: begin
            m_en[cfg_region]  = cfg_wdata[0];
            m_sec[cfg_region] = cfg_wdata[1];
            m_rd[cfg_region]  = cfg_wdata[2];
            m_wr[cfg_region]  = cfg_wdata[3];
          end
        endcase
      end
    end
  end

  // Compare on every falling edge.
  always @(negedge clk) begin
    check("R2 rsp_valid", int'(rsp_valid), int'(e_valid));
    check("R11 err_pulse", int'(err_pulse), int'(e_err));
    check({phase, " rsp_allow"}, int'(rsp_allow), int'(e_allow));
    check({phase, " rsp_hit"}, int'(rsp_hit), int'(e_hit));
    check({phase, " rsp_region"}, int'(rsp_region), e_region);
  end

  task automatic wr(input int r, input int f, input logic [31:0] d);
    cfg_we = 1; cfg_region = 4'(r); cfg_field = 2'(f); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic window(input int r, input logic [31:0] lo, input logic [31:0] hi,
                        input int idv, input int msk, input logic [3:0] at);
    wr(r, 0, lo);
    wr(r, 1, hi);
    wr(r, 2, {6'd0, 10'(msk), 6'd0, 10'(idv)});
    wr(r, 3, {28'd0, at});
  endtask

  task automatic rq(input logic [31:0] a, input int idv, input bit sec, input bit w);
    req_valid = 1; req_addr = a; req_id = 10'(idv); req_secure = sec; req_write = w;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // attribute codes: bit0 en, bit1 sec, bit2 rd, bit3 wr
  initial begin
    @(negedge clk); @(negedge clk);
    phase = "R1";
    rst_n = 1;
    @(negedge clk);
    rq(32'h0000_1000, 0, 1, 0);
    rq(32'h0000_0000, 0, 0, 1);

    phase = "R3";
    window(0, 32'h0000_1ABC, 32'h0000_3001, 0, 0, 4'b1101);
    rq(32'h0000_0FFF, 0, 0, 0);
    rq(32'h0000_1000, 0, 0, 0);
    rq(32'h0000_3FFF, 0, 0, 1);
    rq(32'h0000_4000, 0, 0, 0);

    phase = "R4";
    window(5, 32'h0000_2000, 32'h0000_2FFF, 10'h155, 10'h3F0, 4'b0111);
    rq(32'h0000_2800, 10'h15A, 1, 0);
    rq(32'h0000_2800, 10'h165, 1, 0);

    phase = "R5";
    rq(32'h0000_2000, 10'h150, 1, 0);
    rq(32'h0000_3000, 10'h150, 1, 0);

    phase = "R9";
    rq(32'h0000_2400, 10'h150, 1, 1);
    rq(32'h0000_1400, 10'h3FF, 0, 1);

    phase = "R7";
    rq(32'h0000_2400, 10'h150, 0, 0);

    phase = "R8";
    rq(32'h0000_1800, 10'h001, 1, 0);

    phase = "R6";
    window(15, 32'h0000_0000, 32'hFFFF_FFFF, 0, 0, 4'b1110);
    rq(32'h0000_2400, 10'h150, 1, 0);
    wr(15, 3, 32'hFFFF_FFFD);
    rq(32'h0000_2400, 10'h150, 0, 0);
    wr(15, 3, 32'h0000_0000);

    phase = "R10";
    rq(32'h0010_0000, 10'h000, 1, 0);

    phase = "R12";
    cfg_we = 1; cfg_region = 4'd0; cfg_field = 2'd3; cfg_wdata = 32'h0;
    req_valid = 1; req_addr = 32'h0000_1200; req_id = 0; req_secure = 0; req_write = 0;
    @(negedge clk);
    cfg_we = 0;
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);

    phase = "R5";
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(3) == 0) begin
        int f;
        logic [31:0] d;
        f = $urandom_range(3);
        d = $urandom;
        if (f < 2) d = {12'd0, 4'($urandom_range(15)), d[15:0]};
        if (f == 2) d = d & 32'h03FF_03FF & {16'h0000 | 16'($urandom_range(16'h03FF)), 16'hFFFF};
        cfg_we = 1; cfg_region = 4'($urandom_range(15)); cfg_field = 2'(f); cfg_wdata = d;
      end else cfg_we = 0;
      req_valid  = ($urandom_range(3) != 0);
      req_addr   = {12'd0, 4'($urandom_range(15)), 16'($urandom)};
      req_id     = 10'($urandom);
      req_secure = 1'($urandom);
      req_write  = 1'($urandom);
      @(negedge clk);
    end
    cfg_we = 0; req_valid = 0;
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule